// File: doc/BRIEF.md
# Bus-Master Disk DMA Register Block

This block holds the registers that host software uses to run a bus-master disk DMA engine. There are three of them. A command byte starts or stops a transfer and sets its direction. A status byte reports activity, a sticky error, a sticky interrupt and one DMA-capable flag per drive. A 32-bit pointer gives the base of the descriptor table. Software reaches them over a simple 16-bit register bus with a byte enable per lane, so both byte and word accesses work. The transfer engine reports three events to this block: end of table, bus error and device interrupt. The block drives the engine's run, direction and table base, and it raises an interrupt line.

A small state machine tracks the transfer. It has three states. In `ST_IDLE` the start bit is clear. In `ST_RUN` the start bit is set and the engine is moving data. In `ST_DONE` the engine has reached the end of the table but software has not yet cleared start. It has four transitions:
- *go*: `ST_IDLE` to `ST_RUN`, when start is written as 1.
- *finish*: `ST_RUN` to `ST_DONE`, on an end-of-table event.
- *abort*: `ST_RUN` to `ST_IDLE`, when start is written as 0.
- *release*: `ST_DONE` to `ST_IDLE`, when start is written as 0.

A transfer has completed correctly when status reads active=0, error=0 and interrupt=1.

Register words are selected by `reg_word`, which is the byte offset divided by 2:

| Word | Byte offset | Contents |
|------|-------------|----------|
| 0 | 0x0 | command byte |
| 1 | 0x2 | status byte |
| 2 | 0x4 | pointer bits 15:0 |
| 3 | 0x6 | pointer bits 31:16 |

The upper byte of words 0 and 1 reads as zero.

Top module: `bmdma_regs`

## Requirements
- R1: After reset, all four register words read 0, `eng_run`, `eng_dir`, `eng_abort` and `irq` are 0, and `tbl_base` is 0.
- R2: Writing command bit 0 (start) as 1 while idle causes the following:
  - The block enters `ST_RUN`.
  - From the next cycle, `eng_run` is 1.
  - Status bit 0 (active) reads 1.
  - Command bit 0 reads 1.
  - Writing start as 1 again while running changes nothing.
- R3: An end-of-table event in `ST_RUN` causes the following:
  - Active clears and `eng_run` drops on the next cycle.
  - Command bit 0 stays 1.
  - An end-of-table event outside `ST_RUN` has no effect.
- R4: Writing start as 0 in `ST_RUN` aborts the transfer:
  - Active and `eng_run` clear on the next cycle.
  - `eng_abort` is 1 for exactly that one cycle.
  - Writing start as 0 in `ST_DONE` returns to idle without an abort pulse.
  - A write of start as 0 takes precedence over an end-of-table event in the same cycle.
- R5: Command bit 3 (direction) is read/write and drives `eng_dir`. A value of 1 means the device is read and memory is written. Command bits other than 0 and 3 read 0.
- R6: Status bit 1 (error) works as a sticky flag:
  - A bus error event sets it.
  - Writing it as 1 clears it.
  - Writing it as 0 leaves it unchanged, so a read-modify-write does not clear it.
  - An event in the same cycle as a clearing write leaves it set.
- R7: Status bit 2 (interrupt) follows the same rules as R6, but is set by the device interrupt event. `irq` always equals this flag.
- R8: Status bits 5 and 6 are plain read/write DMA-capable flags for drive 0 and drive 1. Status bit 0 ignores writes. Status bits 3, 4 and 7 read 0.
- R9: The table pointer is 32 bits, in words 2 and 3, and drives `tbl_base`. Its bits 1:0 always read 0 and drive 0.
- R10: A write changes only the byte lanes whose `reg_be` bit is set: bit 0 selects data bits 7:0, bit 1 selects bits 15:8. A read request presents the register word on `reg_rdata` one cycle later, and `reg_rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access request this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_word | input | 2 | Register word index (byte offset / 2) |
| reg_be | input | 2 | Byte-lane enables for writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after a read |
| evt_eot | input | 1 | Engine reached end of descriptor table |
| evt_bus_err | input | 1 | Engine saw a bus error |
| evt_dev_irq | input | 1 | Device raised its interrupt |
| eng_run | output | 1 | Engine is enabled to transfer |
| eng_dir | output | 1 | 1 = device to memory |
| eng_abort | output | 1 | One-cycle pulse when a running transfer is stopped |
| tbl_base | output | 32 | Descriptor table base, 4-byte aligned |
| irq | output | 1 | Interrupt request, equals the status interrupt flag |

## Verification
The start/stop control is tried with three stop patterns:
- A normal end-of-table finish followed by software release.
- A software abort while running.
- A stray end-of-table event while idle.

Together these separate the *finish*, *abort* and *release* transitions, and show which one pulses `eng_abort`.

The status flags get three kinds of write:
- A read-modify-write that writes back 0 in the flag position.
- An explicit write of 1.
- A clear that lands in the same cycle as a new event.

These separate write-one-to-clear from plain read/write and settle the event-wins rule. Byte-lane writes and unaligned pointer values show whether each lane and the pointer's alignment mask are honoured.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } xfer_state_e;

    localparam int PTR_W       = 32;
    localparam int BUS_W       = 16;
    localparam int LANES       = BUS_W / 8;

    localparam int CMD_GO_BIT  = 0;
    localparam int CMD_DIR_BIT = 3;

    localparam int STS_ACT_BIT = 0;
    localparam int STS_ERR_BIT = 1;
    localparam int STS_IRQ_BIT = 2;
    localparam int STS_CAP_LSB = 5;

    localparam logic [1:0] W_CMD    = 2'd0;
    localparam logic [1:0] W_STS    = 2'd1;
    localparam logic [1:0] W_PTR_LO = 2'd2;
    localparam logic [1:0] W_PTR_HI = 2'd3;

endpackage

// File: rtl/bmdma_xfer_fsm.sv
module bmdma_xfer_fsm
    import bmdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_we,
    input  logic wr_go,
    input  logic wr_dir,
    input  logic eot_evt,
    output logic go_bit,
    output logic active,
    output logic dir,
    output logic abort_pulse
);

    xfer_state_e state_q, state_d;
    logic        req_go, req_stop;
    logic        dir_q, abort_q;

    assign req_go   = cmd_we && wr_go;
    assign req_stop = cmd_we && !wr_go;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: go, finish, abort, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_go) state_d = ST_RUN;
            ST_RUN: begin
                if (req_stop)     state_d = ST_IDLE;
                else if (eot_evt) state_d = ST_DONE;
            end
            ST_DONE: if (req_stop) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            if (cmd_we) dir_q <= wr_dir;
            abort_q <= (state_q == ST_RUN) && req_stop;
        end
    end

    assign go_bit      = (state_q != ST_IDLE);
    assign active      = (state_q == ST_RUN);
    assign dir         = dir_q;
    assign abort_pulse = abort_q;

    p_stop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_stop |=> (!active && !go_bit));

    p_go_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_bit) |-> $past(req_go));

    p_eot_finishes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && eot_evt && !req_stop) |=> (!active && go_bit));

    p_abort_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);

endmodule

// File: rtl/bmdma_status.sv
module bmdma_status
    import bmdma_pkg::*;
#(
    parameter int NUM_DRIVES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sts_we,
    input  logic                  wr_err_clr,
    input  logic                  wr_irq_clr,
    input  logic [NUM_DRIVES-1:0] wr_cap,
    input  logic                  buserr_evt,
    input  logic                  devirq_evt,
    output logic                  err_flag,
    output logic                  irq_flag,
    output logic [NUM_DRIVES-1:0] cap
);

    logic err_q, irq_q;

    // events take precedence over a clearing write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (buserr_evt)               err_q <= 1'b1;
            else if (sts_we && wr_err_clr) err_q <= 1'b0;
            if (devirq_evt)               irq_q <= 1'b1;
            else if (sts_we && wr_irq_clr) irq_q <= 1'b0;
        end
    end

    for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_cap
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= 1'b0;
            else if (sts_we) q <= wr_cap[i];
        end
        assign cap[i] = q;
    end

    assign err_flag = err_q;
    assign irq_flag = irq_q;

    p_err_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buserr_evt |=> err_flag);

    p_err_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(sts_we && wr_err_clr)) |=> err_flag);

    p_irq_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !(sts_we && wr_irq_clr)) |=> irq_flag);

    p_irq_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_we && wr_irq_clr && !devirq_evt) |=> !irq_flag);

endmodule

// File: rtl/bmdma_tblptr.sv
module bmdma_tblptr
    import bmdma_pkg::*;
#(
    parameter int ALIGN_BITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W/8-1:0] lane_we,
    input  logic [BUS_W-1:0] wdata,
    output logic [PTR_W-1:0] base
);

    localparam int NBYTES = PTR_W / 8;
    localparam logic [PTR_W-1:0] KEEP_MASK = ~((PTR_W'(1) << ALIGN_BITS) - PTR_W'(1));

    logic [PTR_W-1:0] raw;

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          q <= 8'h00;
            else if (lane_we[i]) q <= wdata[8*(i%LANES) +: 8];
        end
        assign raw[8*i +: 8] = q;
    end

    assign base = raw & KEEP_MASK;

    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we == '0) |=> $stable(base));

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int NUM_DRIVES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_sel,
    input  logic        reg_wr,
    input  logic [1:0]  reg_word,
    input  logic [1:0]  reg_be,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        evt_eot,
    input  logic        evt_bus_err,
    input  logic        evt_dev_irq,
    output logic        eng_run,
    output logic        eng_dir,
    output logic        eng_abort,
    output logic [31:0] tbl_base,
    output logic        irq
);

    logic                  wr_acc, rd_acc;
    logic                  cmd_we, sts_we;
    logic [PTR_W/8-1:0]    ptr_we;
    logic                  go_bit, active, dir;
    logic                  err_flag, irq_flag;
    logic [NUM_DRIVES-1:0] cap;
    logic [7:0]            cmd_byte, sts_byte;
    logic [15:0]           rd_mux, rdata_q;

    assign wr_acc = reg_sel && reg_wr;
    assign rd_acc = reg_sel && !reg_wr;
    assign cmd_we = wr_acc && (reg_word == W_CMD) && reg_be[0];
    assign sts_we = wr_acc && (reg_word == W_STS) && reg_be[0];
    assign ptr_we = { {2{wr_acc && reg_word == W_PTR_HI}} & reg_be,
                      {2{wr_acc && reg_word == W_PTR_LO}} & reg_be };

    bmdma_xfer_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (cmd_we),
        .wr_go       (reg_wdata[CMD_GO_BIT]),
        .wr_dir      (reg_wdata[CMD_DIR_BIT]),
        .eot_evt     (evt_eot),
        .go_bit      (go_bit),
        .active      (active),
        .dir         (dir),
        .abort_pulse (eng_abort)
    );

    bmdma_status #(.NUM_DRIVES(NUM_DRIVES)) u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .sts_we     (sts_we),
        .wr_err_clr (reg_wdata[STS_ERR_BIT]),
        .wr_irq_clr (reg_wdata[STS_IRQ_BIT]),
        .wr_cap     (reg_wdata[STS_CAP_LSB +: NUM_DRIVES]),
        .buserr_evt (evt_bus_err),
        .devirq_evt (evt_dev_irq),
        .err_flag   (err_flag),
        .irq_flag   (irq_flag),
        .cap        (cap)
    );

    bmdma_tblptr #(.ALIGN_BITS(2)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (ptr_we),
        .wdata   (reg_wdata),
        .base    (tbl_base)
    );

    always_comb begin
        cmd_byte              = 8'h00;
        cmd_byte[CMD_GO_BIT]  = go_bit;
        cmd_byte[CMD_DIR_BIT] = dir;
        sts_byte              = 8'h00;
        sts_byte[STS_ACT_BIT] = active;
        sts_byte[STS_ERR_BIT] = err_flag;
        sts_byte[STS_IRQ_BIT] = irq_flag;
        sts_byte[STS_CAP_LSB +: NUM_DRIVES] = cap;
    end

    always_comb begin
        unique case (reg_word)
            W_CMD:    rd_mux = {8'h00, cmd_byte};
            W_STS:    rd_mux = {8'h00, sts_byte};
            W_PTR_LO: rd_mux = tbl_base[15:0];
            W_PTR_HI: rd_mux = tbl_base[31:16];
            default:  rd_mux = 16'h0000;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= 16'h0000;
        else if (rd_acc) rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;
    assign eng_run   = active;
    assign eng_dir   = dir;
    assign irq       = irq_flag;

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(reg_rdata));

    p_run_needs_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_run |-> go_bit);

endmodule

// File: tb/tb_bmdma_regs.sv
`timescale 1ns/1ps
module tb_bmdma_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [1:0]  reg_word = 2'd0, reg_be = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        evt_eot = 1'b0, evt_bus_err = 1'b0, evt_dev_irq = 1'b0;
    logic        eng_run, eng_dir, eng_abort, irq;
    logic [31:0] tbl_base;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    bmdma_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_word(reg_word), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .evt_eot(evt_eot), .evt_bus_err(evt_bus_err),
        .evt_dev_irq(evt_dev_irq), .eng_run(eng_run), .eng_dir(eng_dir),
        .eng_abort(eng_abort), .tbl_base(tbl_base), .irq(irq)
    );

    // behavioural reference: 0 idle, 1 running, 2 finished
    int          m_st;
    bit          m_dir, m_err, m_irq, m_abort;
    bit [1:0]    m_cap;
    bit [31:0]   m_ptr;
    bit [15:0]   m_rd;

    function automatic bit [15:0] m_read(input bit [1:0] w);
        bit [15:0] v = 16'h0;
        case (w)
            2'd0: begin v[0] = (m_st != 0); v[3] = m_dir; end
            2'd1: begin v[0] = (m_st == 1); v[1] = m_err; v[2] = m_irq; v[6:5] = m_cap; end
            2'd2: v = m_ptr[15:0];
            default: v = m_ptr[31:16];
        endcase
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_dir = 0; m_err = 0; m_irq = 0; m_abort = 0;
            m_cap = 0; m_ptr = 0; m_rd = 0;
        end else begin
            bit wcmd, wsts;
            wcmd = reg_sel && reg_wr && reg_word == 2'd0 && reg_be[0];
            wsts = reg_sel && reg_wr && reg_word == 2'd1 && reg_be[0];
            if (reg_sel && !reg_wr) m_rd = m_read(reg_word);
            m_abort = (m_st == 1) && wcmd && !reg_wdata[0];
            if (wcmd && !reg_wdata[0])                m_st = 0;
            else if (m_st == 0 && wcmd && reg_wdata[0]) m_st = 1;
            else if (m_st == 1 && evt_eot)             m_st = 2;
            if (wcmd) m_dir = reg_wdata[3];
            if (evt_bus_err) m_err = 1; else if (wsts && reg_wdata[1]) m_err = 0;
            if (evt_dev_irq) m_irq = 1; else if (wsts && reg_wdata[2]) m_irq = 0;
            if (wsts) m_cap = reg_wdata[6:5];
            if (reg_sel && reg_wr && reg_word == 2'd2) begin
                if (reg_be[0]) m_ptr[7:0]  = reg_wdata[7:0] & 8'hFC;
                if (reg_be[1]) m_ptr[15:8] = reg_wdata[15:8];
            end
            if (reg_sel && reg_wr && reg_word == 2'd3) begin
                if (reg_be[0]) m_ptr[23:16] = reg_wdata[7:0];
                if (reg_be[1]) m_ptr[31:24] = reg_wdata[15:8];
            end
        end
    end

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("R2 eng_run", {31'b0, eng_run}, {31'b0, m_st == 1});
            cmp("R5 eng_dir", {31'b0, eng_dir}, {31'b0, m_dir});
            cmp("R4 eng_abort", {31'b0, eng_abort}, {31'b0, m_abort});
            cmp("R7 irq", {31'b0, irq}, {31'b0, m_irq});
            cmp("R9 tbl_base", tbl_base, m_ptr);
            cmp("R10 reg_rdata", {16'b0, reg_rdata}, {16'b0, m_rd});
        end
    end

    task automatic wr(input bit [1:0] w, input bit [1:0] be, input bit [15:0] d);
        @(negedge clk);
        reg_sel = 1; reg_wr = 1; reg_word = w; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_sel = 0; reg_wr = 0; reg_be = 0;
    endtask

    task automatic rd(input bit [1:0] w, input bit [15:0] exp, input string tag);
        @(negedge clk);
        reg_sel = 1; reg_wr = 0; reg_word = w;
        @(negedge clk);
        reg_sel = 0;
        cmp(tag, {16'b0, reg_rdata}, {16'b0, exp});
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) evt_eot = 1;
        else if (which == 1) evt_bus_err = 1;
        else evt_dev_irq = 1;
        @(negedge clk);
        evt_eot = 0; evt_bus_err = 0; evt_dev_irq = 0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int w = 0; w < 4; w++) rd(w[1:0], 16'h0000, "R1 reset read");
        cmp("R1 irq", {31'b0, irq}, 32'h0);
        // R9 pointer with unaligned low bits
        wr(2'd2, 2'b11, 16'h1237);
        rd(2'd2, 16'h1234, "R9 ptr lo");
        wr(2'd3, 2'b11, 16'hABCD);
        rd(2'd3, 16'hABCD, "R9 ptr hi");
        cmp("R9 base", tbl_base, 32'hABCD1234);
        // R10 byte lane
        wr(2'd3, 2'b01, 16'h5599);
        rd(2'd3, 16'hAB99, "R10 lane0 only");
        wr(2'd0, 2'b10, 16'h0909);
        rd(2'd0, 16'h0000, "R10 cmd upper lane ignored");
        // R8 capability bits, active read-only
        wr(2'd1, 2'b01, 16'h00FF);
        rd(2'd1, 16'h0060, "R8 cap rw others zero");
        // R2/R5 start with direction
        wr(2'd0, 2'b01, 16'h00FF);
        rd(2'd0, 16'h0009, "R5 cmd readback");
        rd(2'd1, 16'h0061, "R2 active");
        wr(2'd0, 2'b01, 16'h0009);
        rd(2'd1, 16'h0061, "R2 restart no change");
        // R7 device interrupt, rmw keeps it
        pulse(2);
        rd(2'd1, 16'h0065, "R7 irq set");
        wr(2'd1, 2'b01, 16'h0061);
        rd(2'd1, 16'h0065, "R7 rmw keeps irq");
        // R3 finish: completion pattern active0 err0 irq1
        pulse(0);
        rd(2'd1, 16'h0064, "R3 finished status");
        rd(2'd0, 16'h0009, "R3 start stays set");
        // release: no abort pulse
        wr(2'd0, 2'b01, 16'h0008);
        cmp("R4 no abort on release", {31'b0, eng_abort}, 32'h0);
        rd(2'd0, 16'h0008, "R4 released");
        wr(2'd1, 2'b01, 16'h0064);
        rd(2'd1, 16'h0060, "R7 irq cleared");
        cmp("R7 irq pin", {31'b0, irq}, 32'h0);
        // R3 stray end-of-table while idle
        pulse(0);
        rd(2'd1, 16'h0060, "R3 eot idle ignored");
        rd(2'd0, 16'h0008, "R3 eot idle cmd");
        // R4 abort
        wr(2'd0, 2'b01, 16'h0001);
        wr(2'd0, 2'b01, 16'h0000);
        cmp("R4 abort pulse", {31'b0, eng_abort}, 32'h1);
        cmp("R4 run dropped", {31'b0, eng_run}, 32'h0);
        rd(2'd1, 16'h0060, "R4 active cleared");
        // R6 error flag
        wr(2'd0, 2'b01, 16'h0001);
        pulse(1);
        rd(2'd1, 16'h0063, "R6 err set");
        wr(2'd1, 2'b01, 16'h0061);
        rd(2'd1, 16'h0063, "R6 rmw keeps err");
        wr(2'd1, 2'b10, 16'hFFFF);
        rd(2'd1, 16'h0063, "R10 status upper lane ignored");
        @(negedge clk);
        evt_bus_err = 1; reg_sel = 1; reg_wr = 1; reg_word = 2'd1; reg_be = 2'b01; reg_wdata = 16'h0062;
        @(negedge clk);
        evt_bus_err = 0; reg_sel = 0; reg_wr = 0; reg_be = 0;
        rd(2'd1, 16'h0063, "R6 event wins over clear");
        wr(2'd1, 2'b01, 16'h0062);
        rd(2'd1, 16'h0061, "R6 err cleared");
        // R4 stop wins over same-cycle end-of-table
        @(negedge clk);
        evt_eot = 1; reg_sel = 1; reg_wr = 1; reg_word = 2'd0; reg_be = 2'b01; reg_wdata = 16'h0000;
        @(negedge clk);
        evt_eot = 0; reg_sel = 0; reg_wr = 0; reg_be = 0;
        cmp("R4 stop beats eot", {31'b0, eng_abort}, 32'h1);
        rd(2'd0, 16'h0000, "R4 idle after stop");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule